// File: doc/BRIEF.md
# Virtually Indexed Physically Tagged Cache Lookup

This block is the lookup stage of a set-associative data cache whose set is chosen from address bits that translation never changes. A request carries only the in-page part of the virtual address (as a word offset). On the cycle the request is accepted, every way's tag, valid bit and line for the chosen set are read into holding registers, while the translation buffer works on the page number in parallel. When the translation buffer later presents the physical page number, that number (joined with any in-page bits above the index) is compared against all held tags at once. One cycle later a single-cycle response reports hit or miss, the matching way and the addressed word.

Line fills arrive on their own port and may come in any cycle. Each fill writes tag, line and valid bit into the way named by a round-robin pointer kept per set. The geometry is parameterised: the index bits plus the line-offset bits must fit within the page offset, and a setting that breaks this stops elaboration. With the defaults (4 KB pages, 32-byte lines, 128 sets, 2 ways, 32-bit physical addresses) the index and line offset exactly fill the 12 in-page bits, the stored tag is the 20-bit page number, and capacity is twice one page.

The controller has three states. IDLE moves to TRANSLATE when a request is accepted. TRANSLATE stays put while no translation is presented, and moves to RESPOND when one is. RESPOND always returns to IDLE after one cycle.

Top module: `vipt_cache_lookup`

## Requirements
- R1: After reset `ready` is 1, `resp_valid` is 0 and every line is invalid, so the first lookup reports a miss.
- R2: The set is `req_woff[IDX_W+WSEL_W-1:WSEL_W]` (byte address bits 11:5 with defaults) and the word within the line is `req_woff[WSEL_W-1:0]` (byte bits 4:2). Lookups to another set never hit a line filled in a different set.
- R3: A request is accepted in a cycle where `ready` and `req_valid` are both 1, and the arrays are read in that same cycle. In the next cycle `ready` is 0.
- R4: While in TRANSLATE with `xlt_valid` low the lookup waits with `resp_valid` 0 and `ready` 0 for any number of cycles. `xlt_valid` in IDLE has no effect: `resp_valid` stays 0 and `ready` stays 1.
- R5: The tag compare happens at the clock edge where `xlt_valid` is 1 in TRANSLATE. `resp_valid` is 1 for exactly the following cycle, after which `ready` is 1 again. In that cycle `resp_hit` is 1 only if a valid way holds the formed tag, `resp_way` is that way, and `resp_data` is the addressed 32-bit word. On a miss `resp_way` and `resp_data` are 0.
- R6: The stored tag is PA_W - IDX_W - OFF_W bits wide (the page number with defaults). A page number that differs from the stored one, even in one bit, misses.
- R7: When `xlt_fault` is 1 together with `xlt_valid`, the response has `resp_fault` 1 and `resp_hit` 0, even if a tag would match.
- R8: A fill writes tag, line and valid bit into the way given by the set's round-robin pointer. Each pointer starts at way 0 after reset and advances by one (wrapping to 0) on each fill to its own set only. Line word w sits at `fill_data[32*w +: 32]`.
- R9: A fill and a request accepted in the same cycle are both taken. The lookup sees the set as it was before the fill and misses; a later lookup of that line hits.
- R10: All ways are compared in parallel: two lines with different page numbers in the same set both hit, in their own ways. A third fill to that set replaces way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request |
| req_woff | input | PAGE_OFF_W-2 (10) | In-page word offset of the virtual address |
| xlt_valid | input | 1 | Translation result present |
| xlt_fault | input | 1 | Translation result is a fault |
| xlt_ppn | input | PA_W-PAGE_OFF_W (20) | Translated physical page number |
| fill_valid | input | 1 | Line fill strobe |
| fill_line | input | PAGE_OFF_W-OFF_W (7) | In-page line number of the fill |
| fill_ppn | input | PA_W-PAGE_OFF_W (20) | Physical page number of the filled line |
| fill_data | input | LINE_BYTES*8 (256) | Line contents |
| ready | output | 1 | Controller in IDLE, request can be taken |
| resp_valid | output | 1 | Response cycle |
| resp_hit | output | 1 | Lookup hit |
| resp_fault | output | 1 | Lookup ended by a translation fault |
| resp_way | output | log2(WAYS) (1) | Way that hit |
| resp_data | output | 32 | Addressed word of the hit line |

## Verification
A line fill and the acceptance of a lookup can land on the same clock edge, and when they target the same set the outcome depends on whether the array read sees the old or the new contents. The bench provokes this by driving `req_valid` and `fill_valid` for one set in the same cycle. It expects that lookup to miss, because the read comes first, and a second lookup of the same line to hit in way 0. Fills landing while a lookup waits in TRANSLATE are also exercised through the round-robin sequences.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_TRANSLATE = 2'd1,
        ST_RESPOND   = 2'd2
    } lk_state_e;

    // Width of an index into n items, never less than one bit.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/vipt_way_store.sv
// One way: tag and line storage plus valid bits, one write port and one
// registered read port. A read on the same edge as a write returns the old
// contents.
module vipt_way_store #(
    parameter int SETS   = 128,
    parameter int IDX_W  = 7,
    parameter int TAG_W  = 20,
    parameter int LINE_W = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              rd_vld,
    output logic [LINE_W-1:0] rd_line
);

    logic [TAG_W-1:0]  tag_mem  [SETS];
    logic [LINE_W-1:0] line_mem [SETS];
    logic [SETS-1:0]   vld_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            line_mem[wr_idx] <= wr_line;
        end
        if (rd_en) begin
            rd_tag  <= tag_mem[rd_idx];
            rd_line <= line_mem[rd_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= '0;
            rd_vld <= 1'b0;
        end else begin
            if (wr_en) begin
                vld_q[wr_idx] <= 1'b1;
            end
            if (rd_en) begin
                rd_vld <= vld_q[rd_idx];
            end
        end
    end

endmodule

// File: rtl/vipt_victim_rr.sv
// Per-set round-robin pointer that names the way a fill replaces.
module vipt_victim_rr #(
    parameter int SETS  = 128,
    parameter int IDX_W = 7,
    parameter int WAYS  = 2,
    parameter int WAY_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic [IDX_W-1:0] set_idx,
    output logic [WAY_W-1:0] victim
);

    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

    logic [WAY_W-1:0] ptr_q [SETS];

    assign victim = ptr_q[set_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                ptr_q[s] <= '0;
            end
        end else if (advance) begin
            if (ptr_q[set_idx] == LAST_WAY) begin
                ptr_q[set_idx] <= '0;
            end else begin
                ptr_q[set_idx] <= ptr_q[set_idx] + WAY_W'(1);
            end
        end
    end

endmodule

// File: rtl/vipt_tag_match.sv
// Parallel compare of one formed tag against the held tag of every way.
module vipt_tag_match #(
    parameter int WAYS  = 2,
    parameter int WAY_W = 1,
    parameter int TAG_W = 20
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tags,
    input  logic [WAYS-1:0]            way_vld,
    input  logic [TAG_W-1:0]           cmp_tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);

    logic [WAYS-1:0] eq;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign eq[w] = way_vld[w] && (way_tags[w] == cmp_tag);
    end

    assign hit = |eq;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (eq[w]) begin
                hit_way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/vipt_cache_lookup.sv
module vipt_cache_lookup
    import vipt_pkg::*;
#(
    parameter int PA_W       = 32,
    parameter int PAGE_OFF_W = 12,
    parameter int LINE_BYTES = 32,
    parameter int SETS       = 128,
    parameter int WAYS       = 2,
    parameter int WORD_W     = 32,
    localparam int OFF_W      = $clog2(LINE_BYTES),
    localparam int IDX_W      = $clog2(SETS),
    localparam int BYTE_W     = $clog2(WORD_W / 8),
    localparam int WSEL_W     = OFF_W - BYTE_W,
    localparam int WOFF_W     = PAGE_OFF_W - BYTE_W,
    localparam int LNUM_W     = PAGE_OFF_W - OFF_W,
    localparam int PPN_W      = PA_W - PAGE_OFF_W,
    localparam int TAG_W      = PA_W - IDX_W - OFF_W,
    localparam int LINE_W     = LINE_BYTES * 8,
    localparam int WAY_W      = int'(idx_width(WAYS))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [WOFF_W-1:0] req_woff,
    input  logic              xlt_valid,
    input  logic              xlt_fault,
    input  logic [PPN_W-1:0]  xlt_ppn,
    input  logic              fill_valid,
    input  logic [LNUM_W-1:0] fill_line,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [LINE_W-1:0] fill_data,
    output logic              ready,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_fault,
    output logic [WAY_W-1:0]  resp_way,
    output logic [WORD_W-1:0] resp_data
);

    localparam int PAD_W = PAGE_OFF_W - IDX_W - OFF_W;

    // Index and line offset must both come from untranslated bits.
    if (IDX_W + OFF_W > PAGE_OFF_W) begin : g_bad_geometry
        $error("vipt_cache_lookup: index plus line offset exceeds page offset");
    end

    lk_state_e state_q, state_d;

    logic              accept;
    logic              compare_now;
    logic [IDX_W-1:0]  req_idx;
    logic [IDX_W-1:0]  fill_idx;
    logic [WSEL_W-1:0] wsel_q;
    logic [TAG_W-1:0]  lk_tag;
    logic [TAG_W-1:0]  fill_tag;
    logic [WAY_W-1:0]  victim;

    logic [WAYS-1:0][TAG_W-1:0] held_tags;
    logic [WAYS-1:0]            held_vld;
    logic [LINE_W-1:0]          held_lines [WAYS];

    logic              match_hit;
    logic [WAY_W-1:0]  match_way;
    logic [LINE_W-1:0] match_line;
    logic [WORD_W-1:0] match_word;

    assign accept      = (state_q == ST_IDLE) && req_valid;
    assign compare_now = (state_q == ST_TRANSLATE) && xlt_valid;
    assign ready       = (state_q == ST_IDLE);

    assign req_idx  = req_woff[IDX_W+WSEL_W-1:WSEL_W];
    assign fill_idx = fill_line[IDX_W-1:0];

    // Tag = page number plus any in-page bits that sit above the index.
    if (PAD_W > 0) begin : g_pad
        logic [PAD_W-1:0] pad_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pad_q <= '0;
            end else if (accept) begin
                pad_q <= req_woff[WOFF_W-1 -: PAD_W];
            end
        end
        assign lk_tag   = {xlt_ppn, pad_q};
        assign fill_tag = {fill_ppn, fill_line[LNUM_W-1 -: PAD_W]};
    end else begin : g_nopad
        assign lk_tag   = xlt_ppn;
        assign fill_tag = fill_ppn;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wsel_q <= '0;
        end else if (accept) begin
            wsel_q <= req_woff[WSEL_W-1:0];
        end
    end

    vipt_victim_rr #(
        .SETS  (SETS),
        .IDX_W (IDX_W),
        .WAYS  (WAYS),
        .WAY_W (WAY_W)
    ) i_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (fill_valid),
        .set_idx (fill_idx),
        .victim  (victim)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic wr_this;
        assign wr_this = fill_valid && (victim == WAY_W'(w));

        vipt_way_store #(
            .SETS   (SETS),
            .IDX_W  (IDX_W),
            .TAG_W  (TAG_W),
            .LINE_W (LINE_W)
        ) i_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_this),
            .wr_idx  (fill_idx),
            .wr_tag  (fill_tag),
            .wr_line (fill_data),
            .rd_en   (accept),
            .rd_idx  (req_idx),
            .rd_tag  (held_tags[w]),
            .rd_vld  (held_vld[w]),
            .rd_line (held_lines[w])
        );
    end

    vipt_tag_match #(
        .WAYS  (WAYS),
        .WAY_W (WAY_W),
        .TAG_W (TAG_W)
    ) i_match (
        .way_tags (held_tags),
        .way_vld  (held_vld),
        .cmp_tag  (lk_tag),
        .hit      (match_hit),
        .hit_way  (match_way)
    );

    assign match_line = held_lines[match_way];
    assign match_word = match_line[int'(wsel_q) * WORD_W +: WORD_W];

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = ST_TRANSLATE;
            ST_TRANSLATE: if (xlt_valid) state_d = ST_RESPOND;
            ST_RESPOND:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Registered response.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_fault <= 1'b0;
            resp_way   <= '0;
            resp_data  <= '0;
        end else begin
            resp_valid <= compare_now;
            resp_fault <= compare_now && xlt_fault;
            if (compare_now && !xlt_fault && match_hit) begin
                resp_hit  <= 1'b1;
                resp_way  <= match_way;
                resp_data <= match_word;
            end else begin
                resp_hit  <= 1'b0;
                resp_way  <= '0;
                resp_data <= '0;
            end
        end
    end

endmodule

// File: rtl/vipt_cache_lookup_chk.sv
module vipt_cache_lookup_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic ready,
    input logic xlt_valid,
    input logic xlt_fault,
    input logic resp_valid,
    input logic resp_hit,
    input logic resp_fault
);

    a_r3_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ready && req_valid |=> !ready);

    a_r4_hold_without_xlt: assert property (@(posedge clk) disable iff (!rst_n)
        !ready && !resp_valid && !xlt_valid |=> !resp_valid && !ready);

    a_r4_idle_xlt_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ready && !req_valid |=> !resp_valid && ready);

    a_r5_resp_follows_xlt: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(xlt_valid) && !$past(ready));

    a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid && ready);

    a_r5_hit_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit |-> resp_valid && !$past(xlt_fault));

    a_r7_fault_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault |-> resp_valid && !resp_hit && $past(xlt_fault));

endmodule

bind vipt_cache_lookup vipt_cache_lookup_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .ready      (ready),
    .xlt_valid  (xlt_valid),
    .xlt_fault  (xlt_fault),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .resp_fault (resp_fault)
);

// File: tb/test_vipt_cache_lookup.sv
`timescale 1ns/1ps
module test_vipt_cache_lookup;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [9:0]   req_woff = '0;
    logic         xlt_valid = 1'b0;
    logic         xlt_fault = 1'b0;
    logic [19:0]  xlt_ppn = '0;
    logic         fill_valid = 1'b0;
    logic [6:0]   fill_line = '0;
    logic [19:0]  fill_ppn = '0;
    logic [255:0] fill_data = '0;
    logic         ready, resp_valid, resp_hit, resp_fault;
    logic [0:0]   resp_way;
    logic [31:0]  resp_data;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    vipt_cache_lookup i_vipt_cache_lookup (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_woff(req_woff),
        .xlt_valid(xlt_valid), .xlt_fault(xlt_fault), .xlt_ppn(xlt_ppn),
        .fill_valid(fill_valid), .fill_line(fill_line), .fill_ppn(fill_ppn),
        .fill_data(fill_data),
        .ready(ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_fault(resp_fault), .resp_way(resp_way), .resp_data(resp_data)
    );

    function automatic logic [31:0] mk_word(input logic [7:0] s, input int w);
        return {s, 8'h5A, ~s, 8'(w)};
    endfunction

    function automatic logic [255:0] mk_line(input logic [7:0] s);
        logic [255:0] l;
        for (int w = 0; w < 8; w++) l[w*32 +: 32] = mk_word(s, w);
        return l;
    endfunction

    task automatic check(input bit ok, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic fill(input logic [31:0] va, input logic [19:0] ppn, input logic [7:0] s);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_line  = va[11:5];
        fill_ppn   = ppn;
        fill_data  = mk_line(s);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    // Lookup: accept, wait `hold` cycles without translation, translate, sample.
    task automatic lookup(input logic [31:0] va, input logic [19:0] ppn, input logic flt,
                          input int hold, output logic rv, output logic hit,
                          output logic way, output logic [31:0] data,
                          output logic fo, output logic held_ok);
        @(negedge clk);
        req_valid = 1'b1;
        req_woff  = va[11:2];
        @(negedge clk);
        req_valid = 1'b0;
        held_ok = !ready && !resp_valid;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (resp_valid || ready) held_ok = 1'b0;
        end
        xlt_valid = 1'b1;
        xlt_ppn   = ppn;
        xlt_fault = flt;
        @(negedge clk);
        xlt_valid = 1'b0;
        xlt_fault = 1'b0;
        rv = resp_valid; hit = resp_hit; way = resp_way[0];
        data = resp_data; fo = resp_fault;
    endtask

    task automatic expect_hit(input string tag, input logic [31:0] va,
                              input logic [19:0] ppn, input logic ew,
                              input logic [7:0] s);
        logic rv, hit, way, fo, ok;
        logic [31:0] data;
        lookup(va, ppn, 1'b0, 0, rv, hit, way, data, fo, ok);
        check(rv && hit, {tag, " hit"}, {30'd0, rv, hit}, 32'd3);
        check(way == ew, {tag, " way"}, {31'd0, way}, {31'd0, ew});
        check(data == mk_word(s, int'(va[4:2])), {tag, " data"}, data,
              mk_word(s, int'(va[4:2])));
    endtask

    task automatic expect_miss(input string tag, input logic [31:0] va,
                               input logic [19:0] ppn);
        logic rv, hit, way, fo, ok;
        logic [31:0] data;
        lookup(va, ppn, 1'b0, 0, rv, hit, way, data, fo, ok);
        check(rv && !hit && way == 1'b0 && data == 32'd0, {tag, " miss"},
              {rv, hit, way, 29'd0} ^ data, 32'h8000_0000);
    endtask

    // va(32) ppn(20) hit(1) way(1) seed(8)
    localparam int NV = 7;
    localparam logic [61:0] VECS [NV] = '{
        {32'h0000_0064, 20'h12345, 1'b1, 1'b0, 8'hA1},  // R5 set 3 way 0
        {32'h7777_706C, 20'h0BEEF, 1'b1, 1'b1, 8'hA2},  // R10 set 3 way 1
        {32'h0000_007C, 20'h54321, 1'b0, 1'b0, 8'h00},  // R6 unknown page
        {32'h0000_0064, 20'h12344, 1'b0, 1'b0, 8'h00},  // R6 one bit off
        {32'hFFFF_FFE0, 20'h00001, 1'b1, 1'b0, 8'hB1},  // R2 top set
        {32'h0000_0000, 20'hFFFFF, 1'b1, 1'b0, 8'hC1},  // R2 set 0
        {32'h0000_0020, 20'h12345, 1'b0, 1'b0, 8'h00}   // R2 other set
    };

    initial begin : wdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic rv, hit, way, fo, ok;
        logic [31:0] data;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ready == 1'b1, "R1 ready after reset", {31'd0, ready}, 32'd1);
        check(resp_valid == 1'b0, "R1 resp_valid after reset", {31'd0, resp_valid}, 32'd0);
        expect_miss("R1 empty cache", 32'h64, 20'h12345);

        // R4 translation while idle has no effect
        @(negedge clk);
        xlt_valid = 1'b1; xlt_ppn = 20'h12345;
        @(negedge clk);
        check(!resp_valid && ready, "R4 idle xlt ignored c1", {30'd0, resp_valid, ready}, 32'd1);
        @(negedge clk);
        check(!resp_valid && ready, "R4 idle xlt ignored c2", {30'd0, resp_valid, ready}, 32'd1);
        xlt_valid = 1'b0;

        // R8 fills: set 3 twice, set 127 once, set 0 once
        fill(32'h60,  20'h12345, 8'hA1);
        fill(32'h60,  20'h0BEEF, 8'hA2);
        fill(32'hFE0, 20'h00001, 8'hB1);
        fill(32'h0,   20'hFFFFF, 8'hC1);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            if (VECS[i][9]) begin
                expect_hit($sformatf("R5 vec %0d", i), VECS[i][61:30], VECS[i][29:10],
                           VECS[i][8], VECS[i][7:0]);
            end else begin
                expect_miss($sformatf("R6 vec %0d", i), VECS[i][61:30], VECS[i][29:10]);
            end
        end

        // R4 lookup waits without translation
        lookup(32'h64, 20'h12345, 1'b0, 5, rv, hit, way, data, fo, ok);
        check(ok, "R4 held without xlt", {31'd0, ok}, 32'd1);
        check(rv && hit && data == mk_word(8'hA1, 1), "R4 result after hold", data,
              mk_word(8'hA1, 1));

        // R7 fault suppresses a matching tag
        lookup(32'h64, 20'h12345, 1'b1, 0, rv, hit, way, data, fo, ok);
        check(rv && fo && !hit, "R7 fault response", {29'd0, rv, fo, hit}, 32'd6);

        // R8/R10 round robin in set 3: third fill replaces way 0
        fill(32'h60, 20'h33333, 8'hD1);
        expect_miss("R10 evicted way 0", 32'h64, 20'h12345);
        expect_hit("R8 new line way 0", 32'h68, 20'h33333, 1'b0, 8'hD1);
        expect_hit("R10 way 1 kept", 32'h6C, 20'h0BEEF, 1'b1, 8'hA2);

        // R8 pointer of set 127 is independent
        fill(32'hFE0, 20'h00002, 8'hB2);
        expect_hit("R8 set 127 second fill way 1", 32'hFE4, 20'h00002, 1'b1, 8'hB2);
        expect_hit("R8 set 127 first fill kept", 32'hFFC, 20'h00001, 1'b0, 8'hB1);

        // R8 pointer wraps: fourth fill to set 3 goes to way 1
        fill(32'h60, 20'h44444, 8'hD2);
        expect_miss("R8 way 1 replaced", 32'h6C, 20'h0BEEF);
        expect_hit("R8 fourth fill way 1", 32'h70, 20'h44444, 1'b1, 8'hD2);
        expect_hit("R8 way 0 kept", 32'h68, 20'h33333, 1'b0, 8'hD1);

        // R9 fill and request accepted in the same cycle, same set
        @(negedge clk);
        req_valid  = 1'b1; req_woff = 10'(32'hA4 >> 2);
        fill_valid = 1'b1; fill_line = 7'd5; fill_ppn = 20'h55555;
        fill_data  = mk_line(8'hE1);
        @(negedge clk);
        req_valid = 1'b0; fill_valid = 1'b0;
        check(!ready, "R3 ready drops after accept", {31'd0, ready}, 32'd0);
        xlt_valid = 1'b1; xlt_ppn = 20'h55555;
        @(negedge clk);
        xlt_valid = 1'b0;
        check(resp_valid && !resp_hit, "R9 same-cycle lookup sees old set",
              {30'd0, resp_valid, resp_hit}, 32'd2);
        @(negedge clk);
        check(ready, "R5 ready after response", {31'd0, ready}, 32'd1);
        expect_hit("R9 line present afterwards", 32'hA4, 20'h55555, 1'b0, 8'hE1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule